// File: doc/BRIEF.md
# Floating-Point Store Execution Unit

This unit carries out one floating-point store at a time. It accepts a 32-bit S-type instruction word and decodes the base and source register indices from it. The caller returns the integer base value and the raw floating-point register contents in the same cycle. The unit adds the sign-extended 12-bit offset to the base to form the virtual address. It then decides whether the operation may proceed at all, and whether the address is naturally aligned for the selected width.

If the store may proceed, the unit asks an external translator for a physical address. It then issues one write on a 64-bit memory bus, with the value moved to the byte lanes given by the low physical address bits and a contiguous byte strobe. It waits for the write response and ends every store it accepts with a one-cycle completion pulse. That pulse carries an exception flag, a cause code and the faulting virtual address. The source bits are written exactly as held in the register, so any NaN payload reaches memory intact.

Checks are made in a fixed order: floating-point enable and width legality first, then alignment, then the translation result, then the memory result. The first failing check decides the cause, and no later step is taken.

Top module: `fp_store_unit`

## Requirements
- R1: `rs1_addr` equals instr[19:15] and `fs2_addr` equals instr[24:20], both combinationally.
- R2: The virtual address on `xlat_vaddr` equals `rs1_val` plus the sign-extended offset {instr[31:25], instr[11:7]}, modulo 2^XLEN.
- R3: funct3 instr[14:12] selects the width: 001 is 2 bytes, 010 is 4 bytes, 011 is 8 bytes. `mem_wstrb` is 8'h03, 8'h0F or 8'hFF shifted left by `mem_addr[2:0]`, and the stored bytes appear on `mem_wdata` shifted left by 8*`mem_addr[2:0]`.
- R4: Only the low 2, 4 or 8 bytes of `fs2_val` are written, bit for bit, with no NaN canonicalization. Higher bits never reach `mem_wdata`, and lanes without a strobe are zero.
- R5: If `fp_enabled` is low, or funct3 is not 001, 010 or 011 (011 only when FLEN >= 64), the store completes with cause 2 and `done_tval` 0. No translation or memory request is made, and this check takes precedence over alignment.
- R6: A virtual address that is not a multiple of the access size completes with cause 6 and `done_tval` equal to that address. No translation or memory request is made.
- R7: A translation response with `xlat_fault` set completes with cause 15 and `done_tval` equal to the virtual address. No memory request is made.
- R8: A memory response with `mem_rsp_err` set completes with cause 13 replaced by 7, that is cause 7 and `done_tval` equal to the virtual address. A clean response completes with `done_exc` 0, cause 0 and `done_tval` 0.
- R9: An instruction whose opcode instr[6:0] is not 7'b0100111 is consumed with no request and no completion pulse.
- R10: `instr_ready` is low from acceptance until the cycle after the completion pulse. `done_valid` lasts exactly one cycle, and `instr_ready` is high in the next cycle.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid and its address, data and strobe hold steady.
- R12: The physical address used on `mem_addr` is the `xlat_paddr` returned with a fault-free translation response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Instruction offered |
| instr_ready | output | 1 | Unit idle, instruction taken this cycle if offered |
| instr | input | 32 | Instruction word |
| rs1_addr | output | 5 | Base register index for the integer register file |
| fs2_addr | output | 5 | Source register index for the floating-point register file |
| rs1_val | input | XLEN | Base register value |
| fs2_val | input | FLEN | Raw floating-point source register value |
| fp_enabled | input | 1 | Floating-point unit enabled |
| xlat_req_valid | output | 1 | Translation request |
| xlat_vaddr | output | XLEN | Virtual address to translate |
| xlat_rsp_valid | input | 1 | Translation response present |
| xlat_fault | input | 1 | Translation failed |
| xlat_paddr | input | XLEN | Translated physical address |
| mem_req_valid | output | 1 | Memory write request |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_addr | output | XLEN | Physical write address |
| mem_wdata | output | 64 | Lane-aligned write data |
| mem_wstrb | output | 8 | Byte strobe |
| mem_rsp_valid | input | 1 | Write response present |
| mem_rsp_err | input | 1 | Write failed |
| done_valid | output | 1 | One-cycle completion pulse |
| done_exc | output | 1 | Store ended in an exception |
| done_cause | output | 5 | Exception cause (2, 6, 7 or 15), 0 on success |
| done_tval | output | XLEN | Faulting virtual address, 0 otherwise |

## Verification
The enable/width check and the alignment check are both evaluated in the cycle an instruction is accepted, so one word can fail both at once. The bench forms such words on purpose, for example a disabled unit or an illegal funct3 paired with an odd address. In those cases it expects cause 2 with a zero fault address, and it expects no translation request. The random mix also lets a misaligned address coincide with a translator that would have faulted, and requires cause 6 with no translation request.

// File: rtl/fp_store_unit.sv
module fp_store_unit #(
  parameter int XLEN = 64,
  parameter int FLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  output logic            instr_ready,
  input  logic [31:0]     instr,
  output logic [4:0]      rs1_addr,
  output logic [4:0]      fs2_addr,
  input  logic [XLEN-1:0] rs1_val,
  input  logic [FLEN-1:0] fs2_val,
  input  logic            fp_enabled,
  output logic            xlat_req_valid,
  output logic [XLEN-1:0] xlat_vaddr,
  input  logic            xlat_rsp_valid,
  input  logic            xlat_fault,
  input  logic [XLEN-1:0] xlat_paddr,
  output logic            mem_req_valid,
  input  logic            mem_req_ready,
  output logic [XLEN-1:0] mem_addr,
  output logic [63:0]     mem_wdata,
  output logic [7:0]      mem_wstrb,
  input  logic            mem_rsp_valid,
  input  logic            mem_rsp_err,
  output logic            done_valid,
  output logic            done_exc,
  output logic [4:0]      done_cause,
  output logic [XLEN-1:0] done_tval
);
  localparam logic [6:0] OPC_FSTORE = 7'b0100111;
  localparam logic [4:0] C_ILLEGAL  = 5'd2;
  localparam logic [4:0] C_MISAL    = 5'd6;
  localparam logic [4:0] C_ACCESS   = 5'd7;
  localparam logic [4:0] C_PAGE     = 5'd15;
  localparam bit         HAS_DBL    = (FLEN >= 64);

  typedef enum logic [2:0] {S_IDLE, S_XLAT, S_REQ, S_WAIT, S_DONE} state_t;
  state_t st;

  logic [XLEN-1:0] vaddr_q, paddr_q, tval_q;
  logic [63:0]     data_q;
  logic [7:0]      strb_q;
  logic [4:0]      cause_q;
  logic            exc_q;

  wire  [2:0]      f3  = instr[14:12];
  wire  [11:0]     imm = {instr[31:25], instr[11:7]};
  wire  [XLEN-1:0] ea  = rs1_val + {{(XLEN-12){imm[11]}}, imm};
  wire             is_store = (instr[6:0] == OPC_FSTORE);
  wire  [63:0]     src64 = 64'(fs2_val);

  logic        width_ok;
  logic [2:0]  amask;
  logic [7:0]  strb_base;
  logic [63:0] data_sel;

  always_comb begin
    width_ok  = 1'b0;
    amask     = 3'b000;
    strb_base = 8'h00;
    data_sel  = 64'd0;
    case (f3)
      3'b001: begin width_ok = 1'b1; amask = 3'b001; strb_base = 8'h03; data_sel = {48'd0, src64[15:0]}; end
      3'b010: begin width_ok = 1'b1; amask = 3'b011; strb_base = 8'h0F; data_sel = {32'd0, src64[31:0]}; end
      3'b011: begin width_ok = HAS_DBL; amask = 3'b111; strb_base = 8'hFF; data_sel = src64; end
      default: ;
    endcase
  end

  wire misal = |(ea[2:0] & amask);

  assign rs1_addr       = instr[19:15];
  assign fs2_addr       = instr[24:20];
  assign instr_ready    = (st == S_IDLE);
  assign xlat_req_valid = (st == S_XLAT);
  assign xlat_vaddr     = vaddr_q;
  assign mem_req_valid  = (st == S_REQ);
  assign mem_addr       = paddr_q;
  assign mem_wdata      = data_q << {paddr_q[2:0], 3'b000};
  assign mem_wstrb      = strb_q << paddr_q[2:0];
  assign done_valid     = (st == S_DONE);
  assign done_exc       = exc_q;
  assign done_cause     = cause_q;
  assign done_tval      = tval_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      vaddr_q <= '0;
      paddr_q <= '0;
      tval_q  <= '0;
      data_q  <= '0;
      strb_q  <= '0;
      cause_q <= '0;
      exc_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (instr_valid && is_store) begin
          vaddr_q <= ea;
          data_q  <= data_sel;
          strb_q  <= strb_base;
          exc_q   <= 1'b0;
          cause_q <= '0;
          tval_q  <= '0;
          if (!fp_enabled || !width_ok) begin
            exc_q <= 1'b1; cause_q <= C_ILLEGAL; st <= S_DONE;
          end else if (misal) begin
            exc_q <= 1'b1; cause_q <= C_MISAL; tval_q <= ea; st <= S_DONE;
          end else begin
            st <= S_XLAT;
          end
        end
        S_XLAT: if (xlat_rsp_valid) begin
          if (xlat_fault) begin
            exc_q <= 1'b1; cause_q <= C_PAGE; tval_q <= vaddr_q; st <= S_DONE;
          end else begin
            paddr_q <= xlat_paddr; st <= S_REQ;
          end
        end
        S_REQ:  if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          if (mem_rsp_err) begin
            exc_q <= 1'b1; cause_q <= C_ACCESS; tval_q <= vaddr_q;
          end
          st <= S_DONE;
        end
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_valid |=> !done_valid && instr_ready); // R10

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr)
      && $stable(mem_wdata) && $stable(mem_wstrb)); // R11

  AST_STRB_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> ($countones(mem_wstrb) == 2 || $countones(mem_wstrb) == 4
      || $countones(mem_wstrb) == 8)); // R3

  AST_REQ_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_wstrb[0] || mem_wstrb[1]); // R6

  AST_DISABLED_TRAP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready && instr_valid && instr[6:0] == OPC_FSTORE && !fp_enabled
      |=> done_valid && done_cause == C_ILLEGAL && !xlat_req_valid); // R5

  AST_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    instr_ready && instr_valid && instr[6:0] != OPC_FSTORE |=> instr_ready); // R9

  AST_PAGE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req_valid && xlat_rsp_valid && xlat_fault
      |=> done_valid && done_cause == C_PAGE && !mem_req_valid); // R7
endmodule

// File: tb/tb_fp_store_unit.sv
module tb_fp_store_unit;
  localparam int XLEN = 64;
  localparam int FLEN = 64;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic            rst_n;
  logic            instr_valid, instr_ready;
  logic [31:0]     instr;
  logic [4:0]      rs1_addr, fs2_addr;
  logic [XLEN-1:0] rs1_val;
  logic [FLEN-1:0] fs2_val;
  logic            fp_enabled;
  logic            xlat_req_valid, xlat_rsp_valid, xlat_fault;
  logic [XLEN-1:0] xlat_vaddr, xlat_paddr;
  logic            mem_req_valid, mem_req_ready;
  logic [XLEN-1:0] mem_addr;
  logic [63:0]     mem_wdata;
  logic [7:0]      mem_wstrb;
  logic            mem_rsp_valid, mem_rsp_err;
  logic            done_valid, done_exc;
  logic [4:0]      done_cause;
  logic [XLEN-1:0] done_tval;

  fp_store_unit #(.XLEN(XLEN), .FLEN(FLEN)) dut (
    .clk(clk), .rst_n(rst_n),
    .instr_valid(instr_valid), .instr_ready(instr_ready), .instr(instr),
    .rs1_addr(rs1_addr), .fs2_addr(fs2_addr),
    .rs1_val(rs1_val), .fs2_val(fs2_val), .fp_enabled(fp_enabled),
    .xlat_req_valid(xlat_req_valid), .xlat_vaddr(xlat_vaddr),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_fault(xlat_fault), .xlat_paddr(xlat_paddr),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_err(mem_rsp_err),
    .done_valid(done_valid), .done_exc(done_exc), .done_cause(done_cause), .done_tval(done_tval)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [6:0] opc, input logic [2:0] f3,
                                      input logic [4:0] r1, input logic [4:0] f2, input logic [11:0] imm);
    return {imm[11:5], f2, r1, f3, imm[4:0], opc};
  endfunction

  function automatic int size_of(input logic [2:0] f3);
    case (f3)
      3'b001: return 2;
      3'b010: return 4;
      3'b011: return (FLEN >= 64) ? 8 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic logic [63:0] low_bytes(input logic [63:0] v, input int n);
    if (n >= 8) return v;
    return v & ((64'd1 << (8 * n)) - 64'd1);
  endfunction

  task automatic idle_inputs();
    instr_valid = 0; xlat_rsp_valid = 0; xlat_fault = 0; xlat_paddr = '0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_err = 0;
  endtask

  task automatic run_store(input logic [31:0] ins, input logic [63:0] r1, input logic [63:0] f2v,
                           input bit fpen, input bit xf, input logic [51:0] page, input bit merr);
    bit              store_op = (ins[6:0] == 7'b0100111);
    int              n        = size_of(ins[14:12]);
    logic [11:0]     imm      = {ins[31:25], ins[11:7]};
    logic [63:0]     ea       = r1 + {{52{imm[11]}}, imm};
    bit              misal    = (n != 0) && ((ea % n) != 0);
    bit              e_exc, e_xlat, e_mem, got, saw_x, saw_m, moved, acc;
    logic [4:0]      e_cause;
    logic [63:0]     e_tval, e_pa, v_seen, a_seen, d_seen;
    logic [7:0]      s_seen;
    e_xlat = 0; e_mem = 0; e_exc = 1; e_tval = 0;
    if (!fpen || n == 0)  e_cause = 5'd2;
    else if (misal)       begin e_cause = 5'd6;  e_tval = ea; end
    else if (xf)          begin e_cause = 5'd15; e_tval = ea; e_xlat = 1; end
    else if (merr)        begin e_cause = 5'd7;  e_tval = ea; e_xlat = 1; e_mem = 1; end
    else                  begin e_cause = 5'd0;  e_exc = 0;   e_xlat = 1; e_mem = 1; end
    e_pa = {page, ea[11:0]};

    @(negedge clk);
    instr = ins; rs1_val = r1; fs2_val = f2v; fp_enabled = fpen; instr_valid = 1;
    #1;
    chk("R1", "rs1_addr", 64'(rs1_addr), 64'(ins[19:15]));
    chk("R1", "fs2_addr", 64'(fs2_addr), 64'(ins[24:20]));
    chk("R10", "ready before accept", 64'(instr_ready), 64'd1);
    @(negedge clk);
    instr_valid = 0; fs2_val = '1; rs1_val = '1;
    if (!store_op) begin
      bit quiet = 1;
      for (int k = 0; k < 4; k++) begin
        if (done_valid || xlat_req_valid || mem_req_valid || !instr_ready) quiet = 0;
        @(negedge clk);
      end
      chk("R9", "foreign opcode quiet", 64'(quiet), 64'd1);
      return;
    end
    got = 0; saw_x = 0; saw_m = 0; moved = 0; acc = 0;
    v_seen = 0; a_seen = 0; d_seen = 0; s_seen = 0;
    for (int k = 0; k < 200 && !got; k++) begin
      if (done_valid) begin
        got = 1;
        chk("R5-R8", "done_exc", 64'(done_exc), 64'(e_exc));
        chk(e_cause == 2 ? "R5" : e_cause == 6 ? "R6" : e_cause == 15 ? "R7" : "R8",
            "done_cause", 64'(done_cause), 64'(e_cause));
        chk("R8", "done_tval", done_tval, e_tval);
        idle_inputs();
      end else begin
        if (xlat_req_valid) begin
          saw_x = 1; v_seen = xlat_vaddr;
          xlat_rsp_valid = ($urandom % 3) != 0;
          xlat_fault = xf; xlat_paddr = {page, xlat_vaddr[11:0]};
        end else xlat_rsp_valid = 0;
        if (acc && !mem_req_valid) begin
          mem_rsp_valid = $urandom % 2; mem_rsp_err = merr;
        end
        if (mem_req_valid) begin
          if (saw_m && (a_seen != mem_addr || d_seen != mem_wdata || s_seen != mem_wstrb)) moved = 1;
          saw_m = 1; a_seen = mem_addr; d_seen = mem_wdata; s_seen = mem_wstrb;
          mem_req_ready = $urandom % 2;
          if (mem_req_ready) acc = 1;
        end else mem_req_ready = 0;
        @(negedge clk);
      end
    end
    chk("R10", "completion pulse seen", 64'(got), 64'd1);
    chk(e_cause == 2 ? "R5" : e_cause == 6 ? "R6" : "R2", "translation asked", 64'(saw_x), 64'(e_xlat));
    chk(e_cause == 15 ? "R7" : "R8", "memory asked", 64'(saw_m), 64'(e_mem));
    if (e_xlat) chk("R2", "xlat_vaddr", v_seen, ea);
    if (e_mem) begin
      chk("R12", "mem_addr", a_seen, e_pa);
      chk("R3", "mem_wstrb", 64'(s_seen), 64'(((8'h01 << n) - 8'h01) << ea[2:0]));
      chk("R4", "mem_wdata", d_seen, low_bytes(f2v, n) << (8 * ea[2:0]));
      chk("R11", "request held", 64'(moved), 64'd0);
    end
    @(negedge clk);
    chk("R10", "pulse ended, ready", {62'd0, done_valid, instr_ready}, 64'd1);
  endtask

  initial begin
    logic [2:0] f3r;
    void'($urandom(32'd2024));
    rst_n = 0; instr = '0; rs1_val = '0; fs2_val = '0; fp_enabled = 0;
    idle_inputs();
    repeat (3) @(negedge clk);
    chk("R10", "reset outputs", {60'd0, instr_ready, done_valid, xlat_req_valid, mem_req_valid}, 64'h8);
    rst_n = 1;

    // R4: half-precision signalling NaN with garbage above bit 15, odd half slot
    run_store(enc(7'h27, 3'b001, 5'd3, 5'd9, 12'h006), 64'h8000_1000, 64'hDEAD_BEEF_CAFE_7D01, 1, 0, 52'h12345, 0);
    // R5 over R6: disabled unit, odd address
    run_store(enc(7'h27, 3'b010, 5'd1, 5'd2, 12'h001), 64'h4000, 64'h1, 0, 0, 52'h1, 0);
    // R5: byte width and reserved width, misaligned too
    run_store(enc(7'h27, 3'b000, 5'd4, 5'd5, 12'h003), 64'h4000, 64'h55, 1, 0, 52'h1, 0);
    run_store(enc(7'h27, 3'b111, 5'd4, 5'd5, 12'h000), 64'h4000, 64'h55, 1, 1, 52'h1, 1);
    // R6 before R7: misaligned word with a translator that would fault
    run_store(enc(7'h27, 3'b010, 5'd6, 5'd7, 12'h002), 64'h9000, 64'h3F80_0000, 1, 1, 52'h2, 0);
    // R7
    run_store(enc(7'h27, 3'b011, 5'd8, 5'd1, 12'h008), 64'h7000, 64'hFFF8_0000_0000_0001, 1, 1, 52'h3, 0);
    // R8 access fault, then clean double at lane 0 with negative offset (R2)
    run_store(enc(7'h27, 3'b010, 5'd8, 5'd1, 12'h004), 64'h7000, 64'h7FC0_0001, 1, 0, 52'h4, 1);
    run_store(enc(7'h27, 3'b011, 5'd31, 5'd31, 12'hFF8), 64'h10, 64'h7FF0_0000_0000_0ABC, 1, 0, 52'hFFFFF, 0);
    // R9
    run_store(enc(7'h07, 3'b010, 5'd2, 5'd3, 12'h000), 64'h100, 64'h0, 1, 0, 52'h0, 0);
    // R2: address wraps past zero
    run_store(enc(7'h27, 3'b001, 5'd2, 5'd3, 12'h800), 64'h400, 64'hABCD, 1, 0, 52'h7, 0);

    for (int i = 0; i < 300; i++) begin
      logic [63:0] base;
      logic [11:0] off;
      case ($urandom % 8)
        0: f3r = 3'($urandom);
        1, 2: f3r = 3'b001;
        3, 4, 5: f3r = 3'b010;
        default: f3r = 3'b011;
      endcase
      base = {$urandom, $urandom};
      off  = 12'($urandom);
      if ($urandom % 4 != 0) base[2:0] = 3'(0 - off[2:0]);
      run_store(enc(($urandom % 10 == 0) ? 7'($urandom) : 7'h27, f3r, 5'($urandom), 5'($urandom), off),
                base, {$urandom, $urandom}, ($urandom % 10) != 0, ($urandom % 10) == 0,
                52'({$urandom, $urandom}), ($urandom % 10) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule